// File: doc/BRIEF.md
# Manchester II Serial Word Encoder

This block sends one framed serial word at a time on a differential line of the kind used by time-division command/response avionics buses. A word takes twenty bit times. The first three bit times carry a sync character whose polarity changes once, in the middle of the sync. The next sixteen bit times carry Manchester II coded data bits. The last bit time carries an odd parity bit.

A send clock at twice the bit rate drives every register, so one send-clock period is half a bit. The block drives a free-running shift clock at the bit rate for the external data source. It raises a data-request strobe while it wants the sixteen payload bits, and it takes those bits one per bit time from a serial input, most significant bit first. Two active-low outputs drive the positive and negative sides of an external line driver. An inhibit input can force both outputs inactive at any time without disturbing the encoder. If enable is still high at the end of a word, the next word follows with no gap.

Top module: `mtx_enc`

## Requirements
- R1: `shiftClk` is low in the first half and high in the second half of each bit time. It toggles on every send-clock edge, and reset clears it to low.
- R2: A word starts at the send-clock edge that ends a bit time (`shiftClk` high before the edge) when `en` is high. `syncSel` is captured at that same edge and held for the whole word.
- R3: The sync takes six half-bit slots. With `syncSel`=1 (command) the line is positive in slots 0-2 and negative in slots 3-5. With `syncSel`=0 (data) the polarity is reversed.
- R4: `dataReq` is high during bit times 2 to 17 (half-bit slots 4 to 35) of a word. `serIn` is captured at the send-clock edge that closes each of those bit times, and the first capture is the most significant data bit.
- R5: The bit captured at the end of bit time b is sent in bit time b+1. A one is positive in the first half and negative in the second half; a zero is the reverse.
- R6: Bit time 19 carries a parity bit, coded as in R5, that makes the number of ones over the sixteen data bits plus parity odd.
- R7: If `en` is high at the edge that closes bit time 19, the next word's slot 0 follows at once, with `syncSel` captured again. Otherwise the block goes idle.
- R8: While idle, both `posN` and `negN` are high and `dataReq` is low.
- R9: While `inhibitN` is low, `posN` and `negN` are both high. Sequencing, data capture and parity are unaffected, so the slots that follow carry the correct levels.
- R10: With `rst` high at a send-clock edge, any word in progress is aborted. After that edge the outputs are quiet and `shiftClk` is low. A new word can start once `rst` is low.
- R11: `posN` low means positive line and `negN` low means negative line. The two are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Send clock, two periods per bit time |
| rst | input | 1 | Synchronous reset and abort, active high |
| en | input | 1 | Request to send a word |
| syncSel | input | 1 | 1 = command sync, 0 = data sync |
| serIn | input | 1 | Serial payload from the external source |
| inhibitN | input | 1 | Low forces both line outputs inactive |
| shiftClk | output | 1 | Bit-rate clock for the data source |
| dataReq | output | 1 | High while payload bits are requested |
| posN | output | 1 | Active-low drive for the positive line side |
| negN | output | 1 | Active-low drive for the negative line side |

## Verification
The bench builds the encoder with the default sixteen-bit payload, so every word is forty half-bit slots long. Each slot is checked against a waveform computed from sync type, data and parity. This covers both sync kinds, all-zero and all-one payloads with their parity extremes, and back-to-back words where `syncSel` changes across the boundary. It also covers an inhibit window in the middle of the payload and a reset part-way through a word followed by a clean restart.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  // Strobes the sequencer hands to the datapath, one cycle wide each.
  typedef struct packed {
    logic start;  // word begins: capture sync kind, clear parity
    logic take;   // capture one payload bit from the serial input
    logic par;    // load the parity bit for the final bit time
  } ctlStrobe_t;
endpackage

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
  import mtx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic busy,
  output logic halfPh,
  output logic [$clog2(2*(DATA_W+4))-1:0] slot,
  output logic dataReq,
  output ctlStrobe_t stb
);
  localparam int SLOTS  = 2 * (DATA_W + 4);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_S   = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] REQ_LO   = SLOT_W'(4);
  localparam logic [SLOT_W-1:0] REQ_HI   = SLOT_W'(2 * (DATA_W + 2) - 1);
  localparam logic [SLOT_W-1:0] PARLOAD  = SLOT_W'(2 * (DATA_W + 2) + 1);

  logic atEnd;
  assign atEnd = busy && (slot == LAST_S);

  always_ff @(posedge clk) begin
    if (rst) begin
      halfPh <= 1'b0;
      busy   <= 1'b0;
      slot   <= '0;
    end else begin
      halfPh <= ~halfPh;
      if (busy) begin
        if (atEnd) begin
          busy <= en;
          slot <= '0;
        end else begin
          slot <= slot + 1'b1;
        end
      end else if (halfPh && en) begin
        busy <= 1'b1;
        slot <= '0;
      end
    end
  end

  assign dataReq   = busy && (slot >= REQ_LO) && (slot <= REQ_HI);
  assign stb.start = halfPh && en && (!busy || atEnd);
  assign stb.take  = dataReq && slot[0];
  assign stb.par   = busy && (slot == PARLOAD);

  AST_PHASE_LOCK: assert property (@(posedge clk) disable iff (rst)
    busy |-> (slot[0] == halfPh)); // R1
  AST_STOP_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
    (atEnd && !en) |=> !busy); // R7
  AST_CHAIN_WORD: assert property (@(posedge clk) disable iff (rst)
    (atEnd && en) |=> (busy && slot == '0)); // R7
  AST_RESET_ABORT: assert property (@(posedge clk)
    rst |=> (!busy && !halfPh)); // R10
endmodule

// File: rtl/mtx_dpath.sv
module mtx_dpath
  import mtx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  ctlStrobe_t stb,
  input  logic busy,
  input  logic [$clog2(2*(DATA_W+4))-1:0] slot,
  input  logic syncSel,
  input  logic serIn,
  output logic drivePos,
  output logic driveNeg
);
  localparam int SLOT_W = $clog2(2 * (DATA_W + 4));
  localparam logic [SLOT_W-1:0] SYNC_MID = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] SYNC_END = SLOT_W'(6);

  logic syncCmd;
  logic curBit;
  logic parAcc;
  logic linePos;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncCmd <= 1'b0;
      curBit  <= 1'b0;
      parAcc  <= 1'b0;
    end else begin
      if (stb.start) begin
        syncCmd <= syncSel;
        parAcc  <= 1'b0;
      end
      if (stb.take) begin
        curBit <= serIn;
        parAcc <= parAcc ^ serIn;
      end
      if (stb.par) begin
        curBit <= ~parAcc;
      end
    end
  end

  always_comb begin
    if (slot < SYNC_END) begin
      linePos = syncCmd ? (slot < SYNC_MID) : (slot >= SYNC_MID);
    end else begin
      linePos = curBit ^ slot[0];
    end
  end

  assign drivePos = busy && linePos;
  assign driveNeg = busy && !linePos;

  AST_PARITY_ODD: assert property (@(posedge clk) disable iff (rst)
    stb.par |=> (curBit != parAcc)); // R6
  AST_SYNC_HELD: assert property (@(posedge clk) disable iff (rst)
    !stb.start |=> $stable(syncCmd)); // R2
endmodule

// File: rtl/mtx_enc.sv
module mtx_enc
  import mtx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic syncSel,
  input  logic serIn,
  input  logic inhibitN,
  output logic shiftClk,
  output logic dataReq,
  output logic posN,
  output logic negN
);
  localparam int SLOT_W = $clog2(2 * (DATA_W + 4));

  ctlStrobe_t stb;
  logic busy;
  logic halfPh;
  logic [SLOT_W-1:0] slot;
  logic drivePos;
  logic driveNeg;

  mtx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .busy(busy), .halfPh(halfPh),
    .slot(slot), .dataReq(dataReq), .stb(stb)
  );

  mtx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .busy(busy), .slot(slot),
    .syncSel(syncSel), .serIn(serIn), .drivePos(drivePos), .driveNeg(driveNeg)
  );

  assign shiftClk = halfPh;
  assign posN = ~(drivePos & inhibitN);
  assign negN = ~(driveNeg & inhibitN);

  AST_NO_BOTH_LOW: assert property (@(posedge clk) disable iff (rst)
    !(!posN && !negN)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (posN && negN && !dataReq)); // R8
endmodule

// File: tb/tb_mtx_enc.sv
module tb_mtx_enc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic syncSel = 1'b0;
  logic serIn = 1'b0;
  logic inhibitN = 1'b1;
  logic shiftClk, dataReq, posN, negN;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mtx_enc dut (
    .clk(clk), .rst(rst), .en(en), .syncSel(syncSel), .serIn(serIn),
    .inhibitN(inhibitN), .shiftClk(shiftClk), .dataReq(dataReq),
    .posN(posN), .negN(negN)
  );

  // {holdEnAfter, syncSel, data}
  localparam logic [17:0] VEC [5] = '{
    {1'b0, 1'b1, 16'hA5C3},
    {1'b1, 1'b0, 16'h0000},
    {1'b1, 1'b1, 16'hFFFF},
    {1'b0, 1'b0, 16'h8001},
    {1'b0, 1'b1, 16'h1234}
  };

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expPos(int s, logic sel, logic [15:0] d);
    int b;
    logic v;
    b = s / 2;
    if (s < 6) return sel ? (s < 3) : (s >= 3);
    if (b <= 18) v = d[18 - b];
    else v = ~(^d);
    return v ^ s[0];
  endfunction

  // Runs one word slot by slot; abortAt >= 0 raises rst in that slot.
  task automatic runWord(logic sel, logic [15:0] d, logic chained, logic hold,
                         logic nextSel, int inhLo, int inhHi, int abortAt);
    logic p, inh;
    string tag;
    if (!chained) begin
      @(negedge clk);
      while (shiftClk !== 1'b1) @(negedge clk);
      en = 1'b1;
      syncSel = sel;
    end
    for (int s = 0; s < 40; s++) begin
      @(negedge clk);
      inh = (s >= inhLo) && (s <= inhHi);
      inhibitN = !inh;
      #1;
      p = expPos(s, sel, d);
      if (inh) tag = "R9";
      else if (s == 0 && !chained) tag = "R2";
      else if (s < 6) tag = chained ? "R7" : "R3";
      else if (s < 38) tag = "R5";
      else tag = "R6";
      check(tag, {2'b00, posN, negN}, {2'b00, !(p && !inh), !(!p && !inh)});
      check("R4", {2'b00, shiftClk, dataReq}, {2'b00, s[0], (s >= 4 && s <= 35)});
      if ((s / 2) >= 2 && (s / 2) <= 17) serIn = d[17 - s / 2];
      else serIn = 1'b0;
      if (s == 39) begin
        en = hold;
        syncSel = nextSel;
      end else begin
        en = 1'b0;
      end
      if (s == abortAt) begin
        rst = 1'b1;
        @(negedge clk);
        #1;
        check("R10", {shiftClk, dataReq, posN, negN}, 4'b0011);
        rst = 1'b0;
        return;
      end
    end
    inhibitN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10", {shiftClk, dataReq, posN, negN}, 4'b0011);
    rst = 1'b0;
    // R8 / R1: idle with enable low, shift clock keeps toggling
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      #1;
      check("R8", {1'b0, dataReq, posN, negN}, 4'b0011);
      check("R1", {3'b000, shiftClk}, {3'b000, k[0] ? 1'b0 : 1'b1});
    end
    for (int i = 0; i < 5; i++) begin
      logic chained, nxt;
      chained = (i > 0) && VEC[i - 1][17];
      nxt = (i < 4) ? VEC[i + 1][16] : 1'b0;
      runWord(VEC[i][16], VEC[i][15:0], chained, VEC[i][17], nxt,
              (i == 4) ? 10 : -1, (i == 4) ? 14 : -1, -1);
    end
    // R7: after a word without hold, the encoder stays idle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #1;
      check("R7", {1'b0, dataReq, posN, negN}, 4'b0011);
    end
    // R10: abort part-way, then a clean restart
    runWord(1'b1, 16'h5A5A, 1'b0, 1'b0, 1'b0, -1, -1, 12);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #1;
      check("R10", {1'b0, dataReq, posN, negN}, 4'b0011);
    end
    runWord(1'b0, 16'h00F1, 1'b0, 1'b0, 1'b0, -1, -1, -1);
    // R11: quiet outputs after the final word, never both low
    @(negedge clk);
    #1;
    check("R11", {2'b00, posN, negN}, 4'b0011);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule